// File: doc/BRIEF.md
# Address-Encoded Register Access Controller

This block is the host-facing control register bank of a network adapter attachment. The host reaches it through a simple synchronous byte bus. Every access carries its intent in the address itself. The low bits pick a byte register, the middle bits pick what to do with it, and the top bits pick which area the access targets. Because the operation code can ask for a bitwise AND or a bitwise OR of the data byte into the register, the host can clear or set single bits in one bus cycle. It does not need a read-modify-write sequence, and so it does not race the adapter, which sets status bits on its own.

The control area holds ten byte registers, arranged as even/odd pairs. They are the host interrupt status pair, the adapter-side status pair, the timer control pair, the timer value pair and the paging pair. The other two areas return read-only bytes: the adapter's encoded network address, and a computed test pattern. The third area is reserved. Any attempt to modify something that cannot be modified is flagged through an access interrupt bit. Interrupts are presented either as an interrupt request or as a channel check, as the host chooses.

Top module: `hca_regbank`

## Requirements
- R1: An access presents a 9-bit address split into three fields. Bits 4:0 select the register (`sel`), bits 6:5 select the operation, and bits 8:7 select the area: 00 control, 01 reserved, 10 identification, 11 test pattern. The control registers sit at `sel` 0x08 to 0x11: 0x08/0x09 host status even/odd, 0x0A/0x0B adapter status even/odd, 0x0C/0x0D timer control, 0x0E/0x0F timer value, 0x10/0x11 paging.
- R2: Operation 00 replaces the addressed control register with the data byte on the next clock edge.
- R3: Operation 01 replaces the addressed control register with (register AND data byte) in a single cycle.
- R4: Operation 10 replaces the addressed control register with (register OR data byte) in a single cycle.
- R5: Operation 11 is a read. On the following cycle `rd_valid` is 1 and `rd_data` holds the value the target had before that clock edge, even if a hardware event updates it in the same cycle. `rd_data` holds its value between reads, and `rd_valid` is 0 after any cycle without a read.
- R6: A modifying operation (00, 01 or 10) to a control-area `sel` outside 0x08..0x11 changes no register and sets the access interrupt, bit 2 of the host status even register. A read of such a `sel` returns 0.
- R7: A modifying operation to any area other than 00 changes no register and sets the access interrupt bit. A read of area 01 returns 0.
- R8: A read of area 10 returns byte `sel` of the 48-bit parameter `ADAPTER_ADDR` (byte 0 = bits 7:0) for `sel` < 6, and 0 for larger values. A read of area 11 returns 8'hA5 XOR (`sel` shifted left by 3).
- R9: Each hardware event sets its status bit on the next edge, and it wins over a host clear in the same cycle. `ev_timer` sets host even bit 4, `ev_fault` sets host even bit 3, and `ev_note[k]` sets host odd bit k+2 (bits 6..2: adapter check, command response, buffer free, adapter command, status response).
- R10: Adapter status odd bits 5, 4, 1 and 0 drive `adp_cmd_new`, `adp_rsp_posted`, `adp_req_free` and `adp_stat_free` directly. `adp_clr[k]` clears bit k of that register on the next edge and wins over a host update in the same cycle.
- R11: An interrupt is pending when host even bits 4..2 or host odd bits 6..2 hold a 1. When host even bit 6 (enable) is 1 and an interrupt is pending, `irq_req` is 1 if host even bit 7 is 1, and `chan_chk` is 1 otherwise. Both are 0 in all other cases.
- R12: After reset, every register is 0 except host even bit 0, which equals parameter `ALT_ADAPTER` (0 primary, 1 alternate). `rd_valid`, `rd_data` and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_addr | input | 9 | Area, operation and register select fields |
| bus_wdata | input | 8 | Data byte for write, AND or OR |
| rd_data | output | 8 | Read result, one cycle after the read |
| rd_valid | output | 1 | rd_data carries a new read result |
| ev_timer | input | 1 | Timer expiry event |
| ev_fault | input | 1 | Internal error event |
| ev_note | input | 5 | Adapter status notifications into host odd bits 6..2 |
| adp_clr | input | 8 | Adapter-side clear of adapter status odd bits |
| adp_cmd_new | output | 1 | Host announced a new command |
| adp_rsp_posted | output | 1 | Host posted a response |
| adp_req_free | output | 1 | Host released the adapter request buffer |
| adp_stat_free | output | 1 | Host released the adapter status buffer |
| irq_req | output | 1 | Interrupt request form |
| chan_chk | output | 1 | Channel check form |

## Verification
The assertions assume that every input is at a known level at each rising edge. They also assume that a bus access is fully described by a single cycle of `bus_en` together with its address, and that event and clear inputs are plain levels that act anew on every edge. The bench changes every input only on the falling edge. It issues at most one access per cycle, and it holds all event and clear inputs low unless a step names them. It deliberately lines up an event with a host clear of the same bit, an adapter clear with a host set of the same bit, and a read with an event on the register being read, so that the priority rules are checked where they decide the outcome.

// File: rtl/hca_pkg.sv
package hca_pkg;

  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 5;
  localparam int OP_W     = 2;
  localparam int AREA_W   = 2;
  localparam int ADDR_W   = SEL_W + OP_W + AREA_W;
  localparam int REG_CNT  = 10;
  localparam int SLOT_W   = $clog2(REG_CNT);
  localparam int ID_BYTES = 6;

  localparam logic [SEL_W-1:0] REG_FIRST = 5'h08;
  localparam logic [SEL_W-1:0] REG_LAST  = 5'h11;

  // slot numbers inside the bank (sel - REG_FIRST)
  localparam int SLOT_HOST_EV = 0;
  localparam int SLOT_HOST_OD = 1;
  localparam int SLOT_ADP_OD  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PUT = 2'b00,
    OP_AND = 2'b01,
    OP_OR  = 2'b10,
    OP_GET = 2'b11
  } hca_op_e;

  typedef enum logic [AREA_W-1:0] {
    AR_CTRL = 2'b00,
    AR_RSVD = 2'b01,
    AR_IDEN = 2'b10,
    AR_PATT = 2'b11
  } hca_area_e;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t apply_op(hca_op_e op, byte_t cur, byte_t din);
    case (op)
      OP_PUT:  return din;
      OP_AND:  return cur & din;
      OP_OR:   return cur | din;
      default: return cur;
    endcase
  endfunction

  function automatic byte_t id_byte(logic [8*ID_BYTES-1:0] addr, logic [SEL_W-1:0] idx);
    byte_t r;
    r = '0;
    for (int i = 0; i < ID_BYTES; i++)
      if (idx == SEL_W'(i)) r = addr[8*i +: 8];
    return r;
  endfunction

  function automatic byte_t patt_byte(logic [SEL_W-1:0] idx);
    return 8'hA5 ^ {idx, 3'b000};
  endfunction

  function automatic logic irq_pending(byte_t host_ev, byte_t host_od);
    return (|host_ev[4:2]) | (|host_od[6:2]);
  endfunction

endpackage

// File: rtl/hca_decode.sv
module hca_decode
  import hca_pkg::*;
(
  input  logic              bus_en,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [SEL_W-1:0]  sel,
  output hca_op_e           op,
  output hca_area_e         area,
  output logic              in_bank,
  output logic [SLOT_W-1:0] slot,
  output logic              mod_hit,
  output logic              rd_req,
  output logic              viol_evt
);
  logic [SEL_W-1:0] diff;
  logic             modify;

  always_comb begin
    sel     = bus_addr[SEL_W-1:0];
    op      = hca_op_e'(bus_addr[SEL_W +: OP_W]);
    area    = hca_area_e'(bus_addr[SEL_W+OP_W +: AREA_W]);
    in_bank = (sel >= REG_FIRST) && (sel <= REG_LAST);
    diff    = sel - REG_FIRST;
    slot    = diff[SLOT_W-1:0];
    modify  = bus_en && (op != OP_GET);
    rd_req  = bus_en && (op == OP_GET);
    mod_hit = modify && (area == AR_CTRL) && in_bank;
    viol_evt = modify && !((area == AR_CTRL) && in_bank);
  end
endmodule

// File: rtl/hca_regfile.sv
module hca_regfile
  import hca_pkg::*;
#(
  parameter logic ALT_ADAPTER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_hit,
  input  hca_op_e           op,
  input  logic [SLOT_W-1:0] slot,
  input  byte_t             wdata,
  input  logic              viol_evt,
  input  logic              ev_timer,
  input  logic              ev_fault,
  input  logic [4:0]        ev_note,
  input  byte_t             adp_clr,
  output byte_t             q [REG_CNT]
);
  for (genvar g = 0; g < REG_CNT; g++) begin : g_slot
    byte_t host_v, set_v, clr_v, nxt;
    localparam byte_t RST_V = (g == SLOT_HOST_EV) ? {7'b0, ALT_ADAPTER} : '0;

    if (g == SLOT_HOST_EV) begin : g_ev
      assign set_v = {3'b000, ev_timer, ev_fault, viol_evt, 2'b00};
      assign clr_v = '0;
    end else if (g == SLOT_HOST_OD) begin : g_od
      assign set_v = {1'b0, ev_note, 2'b00};
      assign clr_v = '0;
    end else if (g == SLOT_ADP_OD) begin : g_adp
      assign set_v = '0;
      assign clr_v = adp_clr;
    end else begin : g_plain
      assign set_v = '0;
      assign clr_v = '0;
    end

    always_comb begin
      host_v = (mod_hit && (slot == SLOT_W'(g))) ? apply_op(op, q[g], wdata) : q[g];
      nxt    = (host_v | set_v) & ~clr_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= RST_V;
      else        q[g] <= nxt;
    end
  end
endmodule

// File: rtl/hca_irq.sv
module hca_irq
  import hca_pkg::*;
(
  input  byte_t host_ev,
  input  byte_t host_od,
  output logic  irq_req,
  output logic  chan_chk
);
  logic fire;
  always_comb begin
    fire     = host_ev[6] && irq_pending(host_ev, host_od);
    irq_req  = fire && host_ev[7];
    chan_chk = fire && !host_ev[7];
  end
endmodule

// File: rtl/hca_regbank.sv
module hca_regbank
  import hca_pkg::*;
#(
  parameter logic [47:0] ADAPTER_ADDR = 48'h0000_0000_0000,
  parameter logic        ALT_ADAPTER  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic [8:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  input  logic        ev_timer,
  input  logic        ev_fault,
  input  logic [4:0]  ev_note,
  input  logic [7:0]  adp_clr,
  output logic        adp_cmd_new,
  output logic        adp_rsp_posted,
  output logic        adp_req_free,
  output logic        adp_stat_free,
  output logic        irq_req,
  output logic        chan_chk
);
  logic [SEL_W-1:0]  sel;
  hca_op_e           op;
  hca_area_e         area;
  logic              in_bank, mod_hit, rd_req, viol_evt;
  logic [SLOT_W-1:0] slot;
  byte_t             q [REG_CNT];
  byte_t             rd_mux;
  byte_t             host_even;

  hca_decode u_dec (
    .bus_en(bus_en), .bus_addr(bus_addr), .sel(sel), .op(op), .area(area),
    .in_bank(in_bank), .slot(slot), .mod_hit(mod_hit), .rd_req(rd_req),
    .viol_evt(viol_evt)
  );

  hca_regfile #(.ALT_ADAPTER(ALT_ADAPTER)) u_rf (
    .clk(clk), .rst_n(rst_n), .mod_hit(mod_hit), .op(op), .slot(slot),
    .wdata(bus_wdata), .viol_evt(viol_evt), .ev_timer(ev_timer),
    .ev_fault(ev_fault), .ev_note(ev_note), .adp_clr(adp_clr), .q(q)
  );

  hca_irq u_irq (
    .host_ev(q[SLOT_HOST_EV]), .host_od(q[SLOT_HOST_OD]),
    .irq_req(irq_req), .chan_chk(chan_chk)
  );

  assign host_even = q[SLOT_HOST_EV];

  always_comb begin
    case (area)
      AR_CTRL: rd_mux = in_bank ? q[slot] : '0;
      AR_IDEN: rd_mux = id_byte(ADAPTER_ADDR, sel);
      AR_PATT: rd_mux = patt_byte(sel);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end

  assign adp_cmd_new    = q[SLOT_ADP_OD][5];
  assign adp_rsp_posted = q[SLOT_ADP_OD][4];
  assign adp_req_free   = q[SLOT_ADP_OD][1];
  assign adp_stat_free  = q[SLOT_ADP_OD][0];
endmodule

// File: rtl/hca_regbank_chk.sv
module hca_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic [8:0] bus_addr,
  input logic       rd_valid,
  input logic       ev_timer,
  input logic [7:0] adp_clr,
  input logic       adp_cmd_new,
  input logic       irq_req,
  input logic       chan_chk,
  input logic       viol_evt,
  input logic [7:0] host_even
);
  p_read_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr[6:5] == 2'b11) |=> rd_valid);

  p_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_addr[6:5] == 2'b11) |=> !rd_valid);

  p_viol_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> host_even[2]);

  p_other_area_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr[8:7] != 2'b00 && bus_addr[6:5] != 2'b11) |=> host_even[2]);

  p_timer_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timer |=> host_even[4]);

  p_adp_clr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adp_clr[5] |=> !adp_cmd_new);

  p_one_form_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_req && chan_chk));

  p_gate_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !host_even[6] |-> (!irq_req && !chan_chk));
endmodule

bind hca_regbank hca_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_addr(bus_addr),
  .rd_valid(rd_valid), .ev_timer(ev_timer), .adp_clr(adp_clr),
  .adp_cmd_new(adp_cmd_new), .irq_req(irq_req), .chan_chk(chan_chk),
  .viol_evt(viol_evt), .host_even(host_even)
);

// File: tb/hca_regbank_test.sv
module hca_regbank_test;
  localparam logic [47:0] ID = 48'h1A2B_3C4D_5E6F;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0;
  logic [8:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, adp_clr = '0;
  logic ev_timer = 0, ev_fault = 0;
  logic [4:0] ev_note = '0;
  logic [7:0] rd_data;
  logic rd_valid, adp_cmd_new, adp_rsp_posted, adp_req_free, adp_stat_free, irq_req, chan_chk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int m [32];
  int exp_rdata = 0;
  bit exp_rvalid = 0;

  always #2ns clk = ~clk;

  hca_regbank #(.ADAPTER_ADDR(ID), .ALT_ADAPTER(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .ev_timer(ev_timer), .ev_fault(ev_fault), .ev_note(ev_note), .adp_clr(adp_clr),
    .adp_cmd_new(adp_cmd_new), .adp_rsp_posted(adp_rsp_posted),
    .adp_req_free(adp_req_free), .adp_stat_free(adp_stat_free),
    .irq_req(irq_req), .chan_chk(chan_chk)
  );

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int model_read(int area, int sel);
    if (area == 0) return (sel >= 8 && sel <= 17) ? m[sel] : 0;
    if (area == 2) return (sel < 6) ? int'((ID >> (8 * sel)) & 48'hFF) : 0;
    if (area == 3) return (165 ^ (sel * 8)) & 255;
    return 0;
  endfunction

  task automatic compare_all(string req);
    bit pend;
    int ev;
    ev = m[8];
    pend = ((ev >> 2) & 7) != 0 || ((m[9] >> 2) & 31) != 0;
    check(req, "rd_valid", int'(rd_valid), int'(exp_rvalid));
    check(req, "rd_data", int'(rd_data), exp_rdata);
    check(req, "irq_req", int'(irq_req), int'(ev[6] && pend && ev[7]));
    check(req, "chan_chk", int'(chan_chk), int'(ev[6] && pend && !ev[7]));
    check(req, "adp_cmd_new", int'(adp_cmd_new), (m[11] >> 5) & 1);
    check(req, "adp_rsp_posted", int'(adp_rsp_posted), (m[11] >> 4) & 1);
    check(req, "adp_req_free", int'(adp_req_free), (m[11] >> 1) & 1);
    check(req, "adp_stat_free", int'(adp_stat_free), m[11] & 1);
  endtask

  // one bus cycle: area, op (0 put,1 and,2 or,3 get), sel
  task automatic cyc(string req, bit en, int area, int op, int sel, int d,
                     bit et = 0, bit ef = 0, int note = 0, int clr = 0);
    bit viol;
    @(negedge clk);
    bus_en = en; bus_addr = 9'((area << 7) | (op << 5) | sel); bus_wdata = 8'(d);
    ev_timer = et; ev_fault = ef; ev_note = 5'(note); adp_clr = 8'(clr);
    exp_rvalid = en && op == 3;
    if (exp_rvalid) exp_rdata = model_read(area, sel);
    viol = 0;
    if (en && op != 3) begin
      if (area == 0 && sel >= 8 && sel <= 17) begin
        if (op == 0) m[sel] = d & 255;
        else if (op == 1) m[sel] = m[sel] & d;
        else m[sel] = m[sel] | d;
      end else viol = 1;
    end
    m[8] = m[8] | (et ? 16 : 0) | (ef ? 8 : 0) | (viol ? 4 : 0);
    m[9] = m[9] | ((note & 31) << 2);
    m[11] = m[11] & ~clr & 255;
    @(posedge clk); #1ns;
    compare_all(req);
  endtask

  task automatic rd(string req, int area, int sel);
    cyc(req, 1, area, 3, sel, 0);
    cyc(req, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (m[i]) m[i] = 0;
    m[8] = 1;
    #10ns; @(negedge clk); rst_n = 1;
    #1ns;
    // R12 reset state at the ports
    compare_all("R12");
    for (int s = 8; s <= 17; s++) rd("R12", 0, s);

    // R2 plain writes, R1 field placement
    for (int s = 12; s <= 17; s++) cyc("R2", 1, 0, 0, s, 16 * s + 3);
    for (int s = 12; s <= 17; s++) rd("R1", 0, s);
    // R3 and R4 single-cycle AND / OR
    cyc("R3", 1, 0, 1, 12, 8'h0F); rd("R3", 0, 12);
    cyc("R4", 1, 0, 2, 13, 8'h80); rd("R4", 0, 13);
    cyc("R3", 1, 0, 1, 13, 8'h81); rd("R3", 0, 13);
    cyc("R4", 1, 0, 2, 16, 8'h0C); rd("R4", 0, 16);

    // R5 read during a same-cycle event returns old value
    cyc("R5", 1, 0, 3, 8, 0, 1, 0, 0, 0);
    rd("R5", 0, 8);
    cyc("R5", 1, 0, 3, 9, 0, 0, 0, 5'h11, 0);
    cyc("R5", 1, 0, 3, 9, 0);
    cyc("R5", 0, 0, 0, 0, 0);

    // R6 invalid control register
    cyc("R6", 1, 0, 1, 8, 8'hE3);   // clear status bits
    cyc("R6", 1, 0, 0, 3, 8'hFF);
    rd("R6", 0, 8);
    rd("R6", 0, 3);
    rd("R6", 0, 20);
    cyc("R6", 1, 0, 2, 31, 8'h01);
    cyc("R6", 1, 0, 1, 8, 8'hFB);

    // R7 other areas ignore modification
    cyc("R7", 1, 1, 0, 9, 8'hFF); rd("R7", 0, 8);
    cyc("R7", 1, 0, 1, 8, 8'hFB);
    cyc("R7", 1, 2, 2, 2, 8'hFF); rd("R7", 0, 8);
    cyc("R7", 1, 0, 1, 8, 8'hFB);
    cyc("R7", 1, 3, 1, 0, 8'h00); rd("R7", 0, 8);
    for (int s = 8; s <= 17; s++) rd("R7", 0, s);
    rd("R7", 1, 9);

    // R8 identification and pattern areas
    for (int s = 0; s < 8; s++) rd("R8", 2, s);
    for (int s = 0; s < 32; s += 5) rd("R8", 3, s);

    // R9 events win over same-cycle host clear
    cyc("R9", 1, 0, 1, 8, 8'h00);
    cyc("R9", 1, 0, 1, 8, 8'h00, 0, 1, 0, 0);
    cyc("R9", 1, 0, 1, 9, 8'h00, 0, 0, 5'h04, 0);
    rd("R9", 0, 8); rd("R9", 0, 9);
    cyc("R9", 1, 0, 0, 9, 8'h00, 0, 0, 5'h10, 0);
    rd("R9", 0, 9);

    // R10 adapter status odd outputs and adapter clear priority
    cyc("R10", 1, 0, 2, 11, 8'h33);
    cyc("R10", 1, 0, 0, 11, 8'h33, 0, 0, 0, 8'h01);
    cyc("R10", 1, 0, 2, 11, 8'h20, 0, 0, 0, 8'h20);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 8'h12);
    rd("R10", 0, 11);

    // R11 interrupt form selection
    cyc("R11", 1, 0, 0, 9, 8'h00);
    cyc("R11", 1, 0, 0, 8, 8'h41);
    cyc("R11", 1, 0, 2, 8, 8'h10);
    cyc("R11", 1, 0, 2, 8, 8'h80);
    cyc("R11", 1, 0, 1, 8, 8'hBF);
    cyc("R11", 1, 0, 2, 8, 8'h40);
    cyc("R11", 1, 0, 1, 8, 8'hEF);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 5'h08, 0);
    cyc("R11", 1, 0, 1, 8, 8'h7F);
    cyc("R11", 1, 0, 0, 9, 8'h00);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule